// File: doc/BRIEF.md
# Fractional Clock Prescaler

This block divides a fast oscillator clock down to a reference for a downstream PLL. Each output period is an integer number of input cycles, but that number may differ from one period to the next. A short repeating pattern of up to eight bits decides, period by period, whether the base divisor or the base divisor plus one is used. The average ratio can therefore land between two integers.

Three configuration inputs drive it: an 8-bit pattern, a 3-bit pattern length code and a 5-bit base divisor. The block adopts these values only at the end of an output period, so every period on the output is whole. It produces a single-cycle reference-enable strobe at the end of each period and a near-square reference clock that is high during the first half of the period.

Top module: `frac_prescaler`

## Requirements
- R1: After reset the block runs with pattern 00h, length code 0 and base divisor 10, whatever the inputs hold. The first period spans 10 input cycles, counting the cycle in which reset is released. During reset `ref_en_o` is 0 and `ref_clk_o` is 1.
- R2: With length code 0 the pattern is ignored, and every period lasts exactly the base divisor in input cycles.
- R3: With a nonzero length code, pattern bit k (bit 0 is the LSB) selects the length of the period that uses pointer k. A 1 gives divisor+1 cycles and a 0 gives divisor cycles.
- R4: With a nonzero length code L, successive periods use pointer 0, 1, …, L and then wrap back to 0. The first period after a period run with code 0 uses pointer 0.
- R5: `ref_en_o` is high for exactly one input cycle, which is the last cycle of each period.
- R6: `ref_clk_o` is high for the first floor(P/2) cycles of a period of P cycles, and low for the rest.
- R7: Changes on the configuration inputs never alter the period in progress. They take effect from the period that begins after the next `ref_en_o` cycle.
- R8: A base divisor of 0 or 1 behaves as 2.
- R9: Length code 7 uses all eight pattern bits, giving a repeat of eight periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pat_i | input | 8 | Pattern of per-period extra-cycle bits |
| len_code_i | input | 3 | Index of the last pattern bit used; 0 bypasses the pattern |
| div_i | input | 5 | Base integer divisor |
| ref_en_o | output | 1 | One-cycle strobe on the last cycle of each period |
| ref_clk_o | output | 1 | Reference clock, high in the first half of each period |

## Verification
Both outputs are decoded from the period counter, so each one is valid in the same cycle as the counter state that produces it. New configuration values are captured on the clock edge that ends a `ref_en_o` cycle, and the first period they shape starts at that edge. The reference model therefore consumes one expected cycle per edge and only reads the configuration inputs at the moment its own period queue runs empty. Its expected values are compared at each falling edge. The directed period measurements start counting at a falling edge on which `ref_en_o` is high, and stop at the next such edge.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;

  // Smallest divisor kept so the output always toggles.
  localparam int MIN_DIV = 2;

  // Base divisor after the floor for degenerate settings.
  function automatic int eff_div(input int d);
    return (d < MIN_DIV) ? MIN_DIV : d;
  endfunction

  // Input cycles in one output period.
  function automatic int period_len(input int d, input logic extra);
    return eff_div(d) + (extra ? 1 : 0);
  endfunction

  // Number of leading high cycles of the reference clock.
  function automatic int high_len(input int len);
    return len / 2;
  endfunction

  // Pointer for the period that follows a boundary.
  function automatic int next_ptr(input int ptr, input int old_len_code,
                                  input int new_len_code);
    if (old_len_code == 0 || ptr >= new_len_code) return 0;
    return ptr + 1;
  endfunction

endpackage

// File: rtl/presc_cfg_hold.sv
module presc_cfg_hold #(
  parameter int DIV_W   = 5,
  parameter int PAT_W   = 8,
  parameter int LCODE_W = 3,
  parameter int DIV_RST = 10,
  parameter int PAT_RST = 0,
  parameter int LEN_RST = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [PAT_W-1:0]   pat_i,
  input  logic [LCODE_W-1:0] len_code_i,
  input  logic [DIV_W-1:0]   div_i,
  output logic [PAT_W-1:0]   act_pat_o,
  output logic [LCODE_W-1:0] act_len_code_o,
  output logic [DIV_W-1:0]   act_div_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_pat_o      <= PAT_W'(PAT_RST);
      act_len_code_o <= LCODE_W'(LEN_RST);
      act_div_o      <= DIV_W'(DIV_RST);
    end else if (load_i) begin
      act_pat_o      <= pat_i;
      act_len_code_o <= len_code_i;
      act_div_o      <= div_i;
    end
  end

endmodule

// File: rtl/presc_seq_ptr.sv
module presc_seq_ptr #(
  parameter int PAT_W   = 8,
  parameter int LCODE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               advance_i,
  input  logic [PAT_W-1:0]   act_pat_i,
  input  logic [LCODE_W-1:0] act_len_code_i,
  input  logic [LCODE_W-1:0] nxt_len_code_i,
  output logic [LCODE_W-1:0] ptr_o,
  output logic               extra_o
);

  logic [LCODE_W-1:0] ptr_d;

  always_comb begin
    ptr_d = LCODE_W'(prescaler_pkg::next_ptr(int'(ptr_o), int'(act_len_code_i),
                                             int'(nxt_len_code_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_o <= '0;
    else if (advance_i) ptr_o <= ptr_d;
  end

  assign extra_o = (act_len_code_i != '0) && act_pat_i[ptr_o];

endmodule

// File: rtl/presc_div_cnt.sv
module presc_div_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cur_len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             period_end_o,
  output logic             ref_en_o,
  output logic             ref_clk_o
);

  logic [CNT_W-1:0] half_len;

  assign half_len     = CNT_W'(prescaler_pkg::high_len(int'(cur_len_i)));
  assign period_end_o = (cnt_o == cur_len_i - CNT_W'(1));
  assign ref_en_o     = period_end_o;
  assign ref_clk_o    = (cnt_o < half_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_o <= '0;
    else if (period_end_o) cnt_o <= '0;
    else                   cnt_o <= cnt_o + CNT_W'(1);
  end

endmodule

// File: rtl/frac_prescaler.sv
module frac_prescaler #(
  parameter int DIV_W   = 5,
  parameter int PAT_W   = 8,
  parameter int DIV_RST = 10,
  parameter int PAT_RST = 0,
  parameter int LEN_RST = 0,
  localparam int LCODE_W = $clog2(PAT_W),
  localparam int CNT_W   = $clog2((1 << DIV_W) + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PAT_W-1:0]   pat_i,
  input  logic [LCODE_W-1:0] len_code_i,
  input  logic [DIV_W-1:0]   div_i,
  output logic               ref_en_o,
  output logic               ref_clk_o
);

  // Named internal events, also observed by the bound checker.
  logic               period_end;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cur_len;
  logic [LCODE_W-1:0] ptr;
  logic               extra;
  logic [PAT_W-1:0]   act_pat;
  logic [LCODE_W-1:0] act_len_code;
  logic [DIV_W-1:0]   act_div;

  presc_cfg_hold #(
    .DIV_W(DIV_W), .PAT_W(PAT_W), .LCODE_W(LCODE_W),
    .DIV_RST(DIV_RST), .PAT_RST(PAT_RST), .LEN_RST(LEN_RST)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(period_end),
    .pat_i(pat_i), .len_code_i(len_code_i), .div_i(div_i),
    .act_pat_o(act_pat), .act_len_code_o(act_len_code), .act_div_o(act_div)
  );

  presc_seq_ptr #(.PAT_W(PAT_W), .LCODE_W(LCODE_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .advance_i(period_end),
    .act_pat_i(act_pat), .act_len_code_i(act_len_code),
    .nxt_len_code_i(len_code_i), .ptr_o(ptr), .extra_o(extra)
  );

  assign cur_len = CNT_W'(prescaler_pkg::period_len(int'(act_div), extra));

  presc_div_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .cur_len_i(cur_len),
    .cnt_o(cnt), .period_end_o(period_end),
    .ref_en_o(ref_en_o), .ref_clk_o(ref_clk_o)
  );

endmodule

// File: rtl/presc_checker.sv
module presc_checker #(
  parameter int DIV_W   = 5,
  parameter int PAT_W   = 8,
  parameter int LCODE_W = 3,
  parameter int CNT_W   = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ref_en_o,
  input logic               ref_clk_o,
  input logic               period_end,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   cur_len,
  input logic [LCODE_W-1:0] ptr,
  input logic [PAT_W-1:0]   act_pat,
  input logic [LCODE_W-1:0] act_len_code,
  input logic [DIV_W-1:0]   act_div
);

  p_cnt_in_period_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < cur_len);

  p_en_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_en_o |=> !ref_en_o);

  p_clk_low_at_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_en_o |-> !ref_clk_o);

  p_clk_high_at_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |=> ref_clk_o);

  p_cfg_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end |=> ($stable(act_div) && $stable(act_len_code) && $stable(act_pat)));

  p_ptr_bounded_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr <= act_len_code);

  p_len_floor_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_len >= CNT_W'(2));

endmodule

bind frac_prescaler presc_checker #(
  .DIV_W(DIV_W), .PAT_W(PAT_W), .LCODE_W(LCODE_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_en_o(ref_en_o), .ref_clk_o(ref_clk_o),
  .period_end(period_end), .cnt(cnt), .cur_len(cur_len), .ptr(ptr),
  .act_pat(act_pat), .act_len_code(act_len_code), .act_div(act_div)
);

// File: tb/tb_frac_prescaler.sv
module tb_frac_prescaler;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pat;
  logic [2:0] lcode;
  logic [4:0] div;
  logic       en, rclk;

  always #2.5 clk = ~clk;

  frac_prescaler dut (
    .clk_i(clk), .rst_ni(rst_n), .pat_i(pat), .len_code_i(lcode),
    .div_i(div), .ref_en_o(en), .ref_clk_o(rclk)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Behavioural model: a queue of expected {en,clk} codes, one per cycle.
  int q[$];
  int m_div, m_pat, m_lc, m_ptr;

  function automatic void plan_period();
    int extra_c, plen;
    extra_c = (m_lc == 0) ? 0 : ((m_pat >> m_ptr) & 1);
    plen = ((m_div > 1) ? m_div : 2) + extra_c;
    for (int k = 0; k < plen; k++)
      q.push_back(((k == plen - 1) ? 2 : 0) + ((2 * k < plen - 1) ? 1 : 0));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_div = 10; m_pat = 0; m_lc = 0; m_ptr = 0;
      plan_period();
    end else begin
      void'(q.pop_front());
      if (q.size() == 0) begin
        m_ptr = (m_lc != 0 && m_ptr < int'(lcode)) ? m_ptr + 1 : 0;
        m_div = int'(div); m_pat = int'(pat); m_lc = int'(lcode);
        plan_period();
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished && q.size() > 0) begin
      chk("R5", "model ref_en", int'(en), (q[0] >> 1) & 1);
      chk("R6", "model ref_clk", int'(rclk), q[0] & 1);
    end
  end

  task automatic measure(input string tag, input int exp);
    int n = 0;
    do begin @(negedge clk); n++; end while (!en);
    chk(tag, "period length", n, exp);
  endtask

  task automatic apply(input logic [7:0] p, input logic [2:0] l, input logic [4:0] d);
    pat = p; lcode = l; div = d;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    // Inputs differ from the reset defaults: R1 expects them unused at first.
    apply(8'hFF, 3'd3, 5'd4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk("R1", "ref_en after reset", int'(en), 0);
    chk("R1", "ref_clk after reset", int'(rclk), 1);
    // First period: 10 cycles including the release cycle.
    measure("R1", 9);
    // Now code 3, all ones, divisor 4: every period is 5.
    for (int i = 0; i < 4; i++) measure("R3", 5);

    apply(8'hFF, 3'd0, 5'd6);           // R2: pattern bypassed
    measure("R2", 6);
    measure("R2", 6);

    apply(8'h00, 3'd0, 5'd1);           // R8: 1 behaves as 2
    measure("R8", 2);
    measure("R8", 2);
    apply(8'h00, 3'd0, 5'd0);           // R8: 0 behaves as 2
    measure("R8", 2);

    apply(8'b0000_0101, 3'd2, 5'd4);    // R3 and R4: bits 1,0,1 repeat
    measure("R4", 5); measure("R4", 4); measure("R4", 5);
    measure("R4", 5); measure("R4", 4); measure("R4", 5);

    apply(8'h00, 3'd0, 5'd3);
    measure("R2", 3);
    apply(8'b1000_0001, 3'd7, 5'd3);    // R9: eight-period repeat
    measure("R9", 4);
    for (int i = 0; i < 6; i++) measure("R9", 3);
    measure("R9", 4);
    measure("R9", 4);

    apply(8'h00, 3'd0, 5'd20);          // R7: change mid-period
    begin
      int n = 0;
      do begin
        @(negedge clk); n++;
        if (n == 5) apply(8'hFF, 3'd0, 5'd7);
      end while (!en);
      chk("R7", "period kept after mid change", n, 20);
    end
    measure("R7", 7);

    apply(8'h00, 3'd0, 5'd9);           // R6: odd period, high for 4
    measure("R6", 9);
    begin
      int hi = 0;
      for (int i = 0; i < 9; i++) begin
        @(negedge clk);
        if (rclk) hi++;
      end
      chk("R6", "high cycles in 9-cycle period", hi, 4);
      chk("R5", "strobe at end of 9-cycle period", int'(en), 1);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL R5 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule